// File: doc/BRIEF.md
# E1 Timeslot-16 Signaling Multiframe Generator

This block produces the bits of timeslot 16 for an E1 transmitter that carries channel-associated signaling. Sixteen basic frames form one signaling multiframe. In frame 0, timeslot 16 carries a four-bit all-zero alignment nibble, three spare (extra) bits and one multiframe alarm bit (the Y bit). In frames 1 to 15 it carries two four-bit ABCD signaling nibbles: one from the lower fifteen voice channels and one from the upper fifteen.

A framer upstream walks the frame counter and the bit counter. For each timeslot-16 bit position it raises `slotValid` for one cycle, with `frameNum` (0 to 15) and `bitNum` (0 to 7) set. `bitNum` 0 is the first bit sent, which is bit 1 of the timeslot. The block answers with the bit to send one clock later.

Control inputs serve several purposes. They can invert one alignment nibble for test. They set the extra and Y bits. They can also override the whole timeslot with all zeros or all ones.

Top module: `e1cas_mf_top`

## Requirements
- R1: While `rstN` is low, `ts16Valid` and `ts16Bit` are both 0.
- R2: `ts16Valid` equals `slotValid` delayed by one clock. `ts16Bit` is 0 in any cycle where `ts16Valid` is 0.
- R3: With no inversion pending and no override, frame 0 with `bitNum` 0 to 3 produces 0.
- R4: A one-cycle `invertReq` is latched. The next frame-0, `bitNum` 0 slot that arrives in a later cycle starts an inverted nibble, so `bitNum` 0 to 3 of that frame produce 1. Only that one nibble is inverted. Several requests before it merge into a single inversion. A request made during or after the `bitNum` 0 slot of a frame 0 waits for the following multiframe.
- R5: With `xDisable` 0, frame 0 produces these extra bits: `extraBits[2]` at `bitNum` 4, `extraBits[1]` at `bitNum` 6, and `extraBits[0]` at `bitNum` 7.
- R6: With `xDisable` 1, frame 0 produces 1 at `bitNum` 4, 6 and 7.
- R7: Frame 0 at `bitNum` 5 produces `yAlarm`.
- R8: In frame n (1 to 15), `bitNum` 0 to 3 produce channel n's nibble and `bitNum` 4 to 7 produce channel n+15's nibble. Channel c (1 to 30) occupies `sigNibbles[4c-1:4c-4]`. Its most significant bit (A) goes out first.
- R9: With `forceOne` 1 and `forceZero` 0, every slot produces 1.
- R10: With `forceZero` 1, every slot produces 0, whatever `forceOne` is.
- R11: A pending inversion is used up by the next frame 0 even when an override hides it. The frame 0 after that is not inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slotValid | input | 1 | A timeslot-16 bit is due this cycle |
| frameNum | input | 4 | Frame index within the multiframe |
| bitNum | input | 3 | Bit index within timeslot 16, 0 sent first |
| sigNibbles | input | 120 | ABCD nibbles of channels 1 to 30 |
| xDisable | input | 1 | Send 1 at the extra bit positions |
| extraBits | input | 3 | Values for the extra bits |
| yAlarm | input | 1 | Multiframe alarm (Y) bit value |
| invertReq | input | 1 | Request to invert one alignment nibble |
| forceZero | input | 1 | Force every timeslot-16 bit to 0 |
| forceOne | input | 1 | Force every timeslot-16 bit to 1 |
| ts16Bit | output | 1 | Timeslot-16 bit, one clock after the slot |
| ts16Valid | output | 1 | `ts16Bit` is meaningful |

## Verification
The only hidden state is the inversion bookkeeping. If it goes wrong, the ports show it at the next frame-0 alignment nibble: a nibble comes out inverted when it should not, a nibble that should be inverted is missed, or two nibbles in a row are inverted. That can be as much as one multiframe after the request. The rest of the output is a function of the current slot, so a wrong field mapping or override priority shows up in the very next output bit. The reference model compares both outputs on every clock across several multiframes. These include requests made during the frame-0 nibble and requests hidden by an override.

// File: rtl/e1cas_pkg.sv
`timescale 1ns/1ps
package e1cas_pkg;
  localparam int FRAME_W   = 4;
  localparam int BIT_W     = 3;
  localparam int NIB_W     = 4;
  localparam int N_CHAN    = 30;
  localparam int HALF_CHAN = N_CHAN / 2;
  localparam int CHAN_W    = $clog2(N_CHAN + 2);
  localparam int SIG_W     = N_CHAN * NIB_W;

  // Strobes from control to datapath for the current slot
  typedef struct packed {
    logic              slot;
    logic              alignPos;
    logic              extraPos;
    logic              yPos;
    logic              invertNow;
    logic [1:0]        extraSel;
    logic [CHAN_W-1:0] chanIdx;
    logic [1:0]        nibbleBit;
  } ctlStrobe_t;
endpackage

// File: rtl/e1cas_ctrl.sv
`timescale 1ns/1ps
module e1cas_ctrl
  import e1cas_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               slotValid,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic [BIT_W-1:0]   bitNum,
  input  logic               invertReq,
  output ctlStrobe_t         strobe
);
  logic invPending;
  logic invActive;
  logic isFrame0;
  logic consume;
  logic nibbleEnd;

  always_comb begin
    isFrame0  = (frameNum == '0);
    consume   = slotValid && isFrame0 && (bitNum == 3'd0) && invPending;
    nibbleEnd = slotValid && isFrame0 && (bitNum == 3'd3);

    strobe.slot      = slotValid;
    strobe.alignPos  = isFrame0 && !bitNum[2];
    strobe.yPos      = isFrame0 && (bitNum == 3'd5);
    strobe.extraPos  = isFrame0 && bitNum[2] && (bitNum != 3'd5);
    strobe.extraSel  = (bitNum == 3'd4) ? 2'd2 : ((bitNum == 3'd6) ? 2'd1 : 2'd0);
    strobe.invertNow = slotValid && isFrame0 && !bitNum[2] &&
                       ((bitNum == 3'd0) ? invPending : invActive);
    strobe.chanIdx   = CHAN_W'(frameNum) + (bitNum[2] ? CHAN_W'(HALF_CHAN) : '0) - CHAN_W'(1);
    strobe.nibbleBit = bitNum[1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      invPending <= 1'b0;
      invActive  <= 1'b0;
    end else begin
      invPending <= invertReq | (invPending & ~consume);
      if (consume)        invActive <= 1'b1;
      else if (nibbleEnd) invActive <= 1'b0;
    end
  end
endmodule

// File: rtl/e1cas_dp.sv
`timescale 1ns/1ps
module e1cas_dp
  import e1cas_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [SIG_W-1:0] sigNibbles,
  input  logic             xDisable,
  input  logic [2:0]       extraBits,
  input  logic             yAlarm,
  input  logic             forceZero,
  input  logic             forceOne,
  output logic             ts16Bit,
  output logic             ts16Valid
);
  logic [NIB_W-1:0] nibArr [N_CHAN];
  logic [NIB_W-1:0] curNib;
  logic             sigBit;
  logic             frameBit;
  logic             nextBit;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_unpack
    assign nibArr[c] = sigNibbles[c*NIB_W +: NIB_W];
  end

  always_comb begin
    curNib = '0;
    for (int c = 0; c < N_CHAN; c++) begin
      if (strobe.chanIdx == CHAN_W'(c)) curNib = nibArr[c];
    end
    sigBit = curNib[~strobe.nibbleBit];

    if (strobe.alignPos)      frameBit = strobe.invertNow;
    else if (strobe.yPos)     frameBit = yAlarm;
    else if (strobe.extraPos) frameBit = xDisable | extraBits[strobe.extraSel];
    else                      frameBit = sigBit;

    if (forceZero)     nextBit = 1'b0;
    else if (forceOne) nextBit = 1'b1;
    else               nextBit = frameBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ts16Bit   <= 1'b0;
      ts16Valid <= 1'b0;
    end else begin
      ts16Valid <= strobe.slot;
      ts16Bit   <= strobe.slot & nextBit;
    end
  end
endmodule

// File: rtl/e1cas_mf_top.sv
`timescale 1ns/1ps
module e1cas_mf_top
  import e1cas_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               slotValid,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic [BIT_W-1:0]   bitNum,
  input  logic [SIG_W-1:0]   sigNibbles,
  input  logic               xDisable,
  input  logic [2:0]         extraBits,
  input  logic               yAlarm,
  input  logic               invertReq,
  input  logic               forceZero,
  input  logic               forceOne,
  output logic               ts16Bit,
  output logic               ts16Valid
);
  ctlStrobe_t strobe;

  e1cas_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .frameNum(frameNum),
    .bitNum(bitNum), .invertReq(invertReq), .strobe(strobe)
  );

  e1cas_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sigNibbles(sigNibbles),
    .xDisable(xDisable), .extraBits(extraBits), .yAlarm(yAlarm),
    .forceZero(forceZero), .forceOne(forceOne),
    .ts16Bit(ts16Bit), .ts16Valid(ts16Valid)
  );
endmodule

// File: rtl/e1cas_mf_chk.sv
`timescale 1ns/1ps
module e1cas_mf_chk
  import e1cas_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               slotValid,
  input logic [FRAME_W-1:0] frameNum,
  input logic [BIT_W-1:0]   bitNum,
  input logic [SIG_W-1:0]   sigNibbles,
  input logic               xDisable,
  input logic [2:0]         extraBits,
  input logic               yAlarm,
  input logic               invertReq,
  input logic               forceZero,
  input logic               forceOne,
  input logic               ts16Bit,
  input logic               ts16Valid
);
  always_comb begin
    if (!rstN) AST_RESET_QUIET: assert (!ts16Valid && !ts16Bit); // R1
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |=> ts16Valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid |=> (!ts16Valid && !ts16Bit)); // R2
  AST_EXTRA_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && frameNum == 4'd0 && bitNum[2] && bitNum != 3'd5 &&
     xDisable && !forceZero && !forceOne) |=> ts16Bit); // R6
  AST_Y_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && frameNum == 4'd0 && bitNum == 3'd5 && !forceZero && !forceOne)
    |=> (ts16Bit == $past(yAlarm))); // R7
  AST_FORCE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && forceOne && !forceZero) |=> ts16Bit); // R9
  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && forceZero) |=> (ts16Valid && !ts16Bit)); // R10
endmodule

bind e1cas_mf_top e1cas_mf_chk u_chk (.*);

// File: tb/e1cas_mf_top_tb.sv
`timescale 1ns/1ps
module e1cas_mf_top_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         slotValid = 1'b0;
  logic [3:0]   frameNum = '0;
  logic [2:0]   bitNum = '0;
  logic [119:0] sigNibbles = '0;
  logic         xDisable = 1'b0;
  logic [2:0]   extraBits = '0;
  logic         yAlarm = 1'b0;
  logic         invertReq = 1'b0;
  logic         forceZero = 1'b0;
  logic         forceOne = 1'b0;
  logic         ts16Bit;
  logic         ts16Valid;

  int compared = 0;
  int mismatched = 0;
  int mPend = 0;
  int mAct = 0;
  bit r11Watch = 0;
  bit done = 0;

  always #5 clk = ~clk;

  e1cas_mf_top u_dut (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .frameNum(frameNum),
    .bitNum(bitNum), .sigNibbles(sigNibbles), .xDisable(xDisable),
    .extraBits(extraBits), .yAlarm(yAlarm), .invertReq(invertReq),
    .forceZero(forceZero), .forceOne(forceOne),
    .ts16Bit(ts16Bit), .ts16Valid(ts16Valid)
  );

  // Compare at the falling edge, using the inputs sampled at the last rising edge
  task automatic tick();
    logic expB;
    logic expV;
    logic [3:0] nib;
    string tag;
    int ch;
    bit inv;
    bit consume;
    @(negedge clk);
    expV = slotValid;
    expB = 1'b0;
    tag  = "R2";
    inv  = 0;
    if (slotValid) begin
      if (frameNum == 0) begin
        inv = (bitNum < 4) && ((bitNum == 0) ? (mPend != 0) : (mAct != 0));
        case (bitNum)
          0, 1, 2, 3: begin expB = inv; tag = r11Watch ? "R11" : (inv ? "R4" : "R3"); end
          4: begin expB = xDisable | extraBits[2]; tag = xDisable ? "R6" : "R5"; end
          5: begin expB = yAlarm; tag = "R7"; end
          6: begin expB = xDisable | extraBits[1]; tag = xDisable ? "R6" : "R5"; end
          default: begin expB = xDisable | extraBits[0]; tag = xDisable ? "R6" : "R5"; end
        endcase
      end else begin
        ch   = int'(frameNum) + ((bitNum >= 4) ? 15 : 0);
        nib  = sigNibbles[(ch-1)*4 +: 4];
        expB = nib[3 - (bitNum % 4)];
        tag  = "R8";
      end
      if (forceZero) begin expB = 1'b0; tag = "R10"; end
      else if (forceOne) begin expB = 1'b1; tag = "R9"; end
    end
    compared++;
    if (ts16Valid !== expV || ts16Bit !== expB) begin
      mismatched++;
      $display("FAIL %s frame=%0d bit=%0d actual valid=%b bit=%b expected valid=%b bit=%b",
               tag, frameNum, bitNum, ts16Valid, ts16Bit, expV, expB);
    end
    consume = slotValid && frameNum == 0 && bitNum == 0 && mPend != 0;
    if (consume) mAct = 1;
    else if (slotValid && frameNum == 0 && bitNum == 3) mAct = 0;
    mPend = (invertReq || (mPend != 0 && !consume)) ? 1 : 0;
  endtask

  task automatic sendMf(int invAt);
    for (int f = 0; f < 16; f++) begin
      for (int b = 0; b < 8; b++) begin
        slotValid = 1'b1;
        frameNum  = 4'(f);
        bitNum    = 3'(b);
        invertReq = (f == 0 && b == invAt);
        tick();
        invertReq = 1'b0;
      end
      slotValid = 1'b0;
      tick();
      tick();
    end
  endtask

  task automatic pulseInv();
    invertReq = 1'b1;
    tick();
    invertReq = 1'b0;
    tick();
  endtask

  task automatic newNibbles();
    for (int i = 0; i < 4; i++) sigNibbles[i*32 +: 24] = 24'($urandom);
    sigNibbles[119:96] = 24'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (ts16Valid !== 1'b0 || ts16Bit !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 actual valid=%b bit=%b expected valid=0 bit=0", ts16Valid, ts16Bit);
    end
    rstN = 1'b1;
    tick();

    // Plain multiframe, extra bits 101, Y clear (R3 R5 R7 R8)
    newNibbles(); extraBits = 3'b101; yAlarm = 1'b0;
    sendMf(-1);
    // Two requests merge into one inversion (R4), Y set
    newNibbles(); extraBits = 3'b010; yAlarm = 1'b1;
    pulseInv(); pulseInv();
    sendMf(-1);
    sendMf(-1);
    // Request during the frame-0 nibble waits one multiframe (R4), extra disabled (R6)
    xDisable = 1'b1; newNibbles();
    sendMf(2);
    sendMf(-1);
    // Request in the same cycle as bit 0 of frame 0 waits as well (R4)
    xDisable = 1'b0; extraBits = 3'b011;
    sendMf(0);
    sendMf(-1);
    // Overrides (R9 R10); inversion used up while hidden (R11)
    forceOne = 1'b1;
    sendMf(-1);
    forceZero = 1'b1;
    pulseInv();
    sendMf(-1);
    forceOne = 1'b0;
    sendMf(-1);
    forceZero = 1'b0;
    r11Watch = 1;
    sendMf(-1);
    r11Watch = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule